// File: doc/BRIEF.md
# Multi-Port Register Slave with Selective Reset

This block is an AXI4-Lite slave that serves a register space divided among several MAC ports, four by default. Each port owns a bank with five register classes: configuration, scratch, reset-control, status and saturating statistics counters. Each port also has an enable input and a set of one-cycle event inputs that feed its counters and status flags. Everything runs on the interface clock, which must reach 300 MHz.

There are two reset inputs. The interface reset (active low) aborts any transaction in flight. It clears the counters, status flags, scratch and reset-control registers, and it leaves configuration untouched. The global core reset (active high) clears every register, including configuration. While the core reset is held, every response is an error.

An access to a disabled port or to an unmapped offset is not an error. It completes with OKAY, returns zero on a read and raises one of two debug flags for one cycle. The write channels follow valid/ready rules. Address and data may arrive in either order, and each is held until the other arrives. BVALID and RVALID, with their payloads, stay asserted and stable until the master raises BREADY or RREADY. While a response waits for its ready, the slave accepts no new request of that type.

Top module: `mpreg_axil_slave`

## Requirements
- R1: AW and W are accepted independently and in either order, and only one write is outstanding at a time. BVALID rises on the clock edge after both have been captured and stays high, with BRESP stable, until BREADY. AWREADY is low from the AW handshake until the response completes, and WREADY is low from the W handshake until the response completes.
- R2: RVALID rises on the clock edge that completes the AR handshake and stays high, with RDATA and RRESP stable, until RREADY. ARREADY is low while RVALID is high.
- R3: While the interface reset is low, BVALID, RVALID and both debug flags are low, and a write whose address has been captured is dropped. The reset clears the counters, status flags, scratch and reset-control registers of all ports. Once the reset is released, the counters count again from zero.
- R4: Configuration registers keep their contents through the interface reset. Only the core reset clears them.
- R5: While the core reset is low, every response is OKAY (2'b00). While it is high, every response is SLVERR (2'b10), read data is zero, and neither debug flag pulses.
- R6: Byte address bits [11:10] select the port, and bits [9:2] select the word offset. Offsets 0x00-0x0F are configuration, 0x10-0x13 scratch, 0x14-0x17 reset-control, 0x18-0x1B status and 0x20-0x27 counters. All other offsets are unmapped.
- R7: A write to a writable register updates byte lane i (bits 8i+7:8i) only when WSTRB[i] is 1.
- R8: A write to a status or counter offset leaves the register unchanged and completes with OKAY.
- R9: Counter i of port p sits at offset 0x20+i and is driven by event bit p*8+i. It increments on each cycle in which that bit is high and the port is enabled. It is CNT_W bits wide (32 by default), reads zero-extended and saturates at all ones.
- R10: Status word s (offset 0x18+s) holds sticky flags. Bit b of that word is set once event b*4+s occurs while the port is enabled.
- R11: An access to a disabled port completes with OKAY, reads zero and ignores write data. It raises dbg_dis_o for exactly the first cycle of its response valid. This flag takes precedence over the unmapped flag.
- R12: An access to an unmapped offset on an enabled port completes with OKAY, reads zero and ignores write data. It raises dbg_unm_o for exactly the first cycle of its response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| aresetn_i | input | 1 | Interface reset, active low, synchronous |
| core_rst_i | input | 1 | Global core reset, active high, synchronous |
| port_en_i | input | NPORTS | Per-port enable |
| evt_i | input | NPORTS*8 | One-cycle counter events, 8 per port |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 12 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 12 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| dbg_dis_o | output | 1 | One-cycle pulse for an access to a disabled port |
| dbg_unm_o | output | 1 | One-cycle pulse for an access to an unmapped offset |

## Verification
The properties assume that both resets are synchronous to the interface clock. They also assume that the core reset is sampled with the request that produces a response, so a response code can be traced to the core-reset level one cycle earlier. The stimulus drives every input on the falling edge. It holds each valid, with a stable payload, until the handshake, and it changes the core reset only between transactions. Back-pressure is exercised by holding BREADY or RREADY low for several cycles.

// File: rtl/mpreg_pkg.sv
package mpreg_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W = 8;
  localparam int NCFG = 16;
  localparam int SCR_BASE = 16;
  localparam int NSCR = 4;
  localparam int RCT_BASE = 20;
  localparam int NRCT = 4;
  localparam int STS_BASE = 24;
  localparam int NSTS = 4;
  localparam int CNT_BASE = 32;
  localparam int NCNT = 8;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {RG_CFG, RG_SCR, RG_RCT, RG_STS, RG_CNT, RG_NONE} region_e;

  function automatic region_e region_of(input logic [OFF_W-1:0] off);
    if (off < OFF_W'(NCFG)) return RG_CFG;
    if (off < OFF_W'(SCR_BASE + NSCR)) return RG_SCR;
    if (off < OFF_W'(RCT_BASE + NRCT)) return RG_RCT;
    if (off < OFF_W'(STS_BASE + NSTS)) return RG_STS;
    if (off >= OFF_W'(CNT_BASE) && off < OFF_W'(CNT_BASE + NCNT)) return RG_CNT;
    return RG_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/mpreg_stat_ctr.sv
module mpreg_stat_ctr #(
  parameter int W = 32
)(
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (clr_i) cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/mpreg_port_bank.sv
module mpreg_port_bank import mpreg_pkg::*; #(
  parameter int CNT_W = 32
)(
  input  logic              clk_i,
  input  logic              ifc_rst_i,
  input  logic              core_rst_i,
  input  logic              en_i,
  input  logic [NCNT-1:0]   evt_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              soft_clr;
  logic [DATA_W-1:0] cfg_q [NCFG];
  logic [DATA_W-1:0] scr_q [NSCR];
  logic [DATA_W-1:0] rct_q [NRCT];
  logic [NCNT-1:0]   sts_q;
  logic [CNT_W-1:0]  cnt_w [NCNT];
  logic [DATA_W-1:0] sts_word [NSTS];

  assign soft_clr = ifc_rst_i | core_rst_i;

  always_ff @(posedge clk_i) begin
    if (core_rst_i) begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NCFG; i++)
        if (wr_off_i == OFF_W'(i)) cfg_q[i] <= merge_lanes(cfg_q[i], wr_data_i, wr_strb_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (soft_clr) begin
      for (int i = 0; i < NSCR; i++) scr_q[i] <= '0;
      for (int i = 0; i < NRCT; i++) rct_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NSCR; i++)
        if (wr_off_i == OFF_W'(SCR_BASE + i)) scr_q[i] <= merge_lanes(scr_q[i], wr_data_i, wr_strb_i);
      for (int i = 0; i < NRCT; i++)
        if (wr_off_i == OFF_W'(RCT_BASE + i)) rct_q[i] <= merge_lanes(rct_q[i], wr_data_i, wr_strb_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (soft_clr) sts_q <= '0;
    else if (en_i) sts_q <= sts_q | evt_i;
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_ctr
    mpreg_stat_ctr #(.W(CNT_W)) ctr_i (
      .clk_i (clk_i),
      .clr_i (soft_clr),
      .inc_i (en_i & evt_i[c]),
      .cnt_o (cnt_w[c])
    );
  end

  always_comb begin
    for (int s = 0; s < NSTS; s++) begin
      sts_word[s] = '0;
      for (int e = 0; e < NCNT; e++)
        if (e % NSTS == s) sts_word[s][e / NSTS] = sts_q[e];
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCFG; i++)
      if (rd_off_i == OFF_W'(i)) rd_data_o = cfg_q[i];
    for (int i = 0; i < NSCR; i++)
      if (rd_off_i == OFF_W'(SCR_BASE + i)) rd_data_o = scr_q[i];
    for (int i = 0; i < NRCT; i++)
      if (rd_off_i == OFF_W'(RCT_BASE + i)) rd_data_o = rct_q[i];
    for (int i = 0; i < NSTS; i++)
      if (rd_off_i == OFF_W'(STS_BASE + i)) rd_data_o = sts_word[i];
    for (int i = 0; i < NCNT; i++)
      if (rd_off_i == OFF_W'(CNT_BASE + i)) rd_data_o = DATA_W'(cnt_w[i]);
  end
endmodule

// File: rtl/mpreg_axil_if.sv
module mpreg_axil_if import mpreg_pkg::*; #(
  parameter int ADDR_W = 12
)(
  input  logic              clk_i,
  input  logic              aresetn_i,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o,
  output logic              rd_fire_o,
  input  logic [1:0]        bresp_i,
  input  logic [1:0]        rresp_i,
  input  logic [DATA_W-1:0] rdata_i
);
  logic aw_held, w_held;

  assign s_awready = !aw_held && !s_bvalid;
  assign s_wready  = !w_held && !s_bvalid;
  assign wr_fire_o = aw_held && w_held && !s_bvalid;
  assign s_arready = !s_rvalid;
  assign rd_fire_o = s_arvalid && s_arready;

  always_ff @(posedge clk_i) begin
    if (!aresetn_i) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OKAY;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_held   <= 1'b1;
        wr_addr_o <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_held    <= 1'b1;
        wr_data_o <= s_wdata;
        wr_strb_o <= s_wstrb;
      end
      if (wr_fire_o) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        s_bvalid <= 1'b1;
        s_bresp  <= bresp_i;
      end else if (s_bvalid && s_bready) begin
        s_bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!aresetn_i) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      s_rresp  <= RESP_OKAY;
    end else if (rd_fire_o) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rdata_i;
      s_rresp  <= rresp_i;
    end else if (s_rvalid && s_rready) begin
      s_rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/mpreg_axil_slave.sv
module mpreg_axil_slave import mpreg_pkg::*; #(
  parameter int NPORTS = 4,
  parameter int CNT_W = 32,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int ADDR_W = OFF_W + 2 + PORT_W,
  localparam int NEVT = NPORTS * NCNT
)(
  input  logic              clk_i,
  input  logic              aresetn_i,
  input  logic              core_rst_i,
  input  logic [NPORTS-1:0] port_en_i,
  input  logic [NEVT-1:0]   evt_i,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              dbg_dis_o,
  output logic              dbg_unm_o
);
  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rdata_d;
  logic [STRB_W-1:0] wr_strb;
  logic [PORT_W-1:0] wr_port, rd_port;
  logic [OFF_W-1:0]  wr_off, rd_off;
  logic              wr_dis, wr_unm, rd_dis, rd_unm, wr_ok;
  logic [1:0]        resp_d;
  logic [NPORTS-1:0] bank_we;
  logic [DATA_W-1:0] bank_rd [NPORTS];

  mpreg_axil_if #(.ADDR_W(ADDR_W)) if_i (
    .clk_i, .aresetn_i,
    .s_awvalid, .s_awready, .s_awaddr,
    .s_wvalid, .s_wready, .s_wdata, .s_wstrb,
    .s_bvalid, .s_bready, .s_bresp,
    .s_arvalid, .s_arready,
    .s_rvalid, .s_rready, .s_rdata, .s_rresp,
    .wr_fire_o (wr_fire),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .wr_strb_o (wr_strb),
    .rd_fire_o (rd_fire),
    .bresp_i   (resp_d),
    .rresp_i   (resp_d),
    .rdata_i   (rdata_d)
  );

  // Address split: port index above the word offset, byte bits dropped.
  assign wr_port = wr_addr[2+OFF_W +: PORT_W];
  assign wr_off  = wr_addr[2 +: OFF_W];
  assign rd_port = s_araddr[2+OFF_W +: PORT_W];
  assign rd_off  = s_araddr[2 +: OFF_W];

  assign wr_dis = !port_en_i[wr_port];
  assign wr_unm = region_of(wr_off) == RG_NONE;
  assign rd_dis = !port_en_i[rd_port];
  assign rd_unm = region_of(rd_off) == RG_NONE;
  assign wr_ok  = !core_rst_i && !wr_dis && !wr_unm;
  assign resp_d = core_rst_i ? RESP_SLVERR : RESP_OKAY;

  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      bank_we[p] = wr_fire && wr_ok && (wr_port == PORT_W'(p));
  end

  assign rdata_d = (core_rst_i || rd_dis || rd_unm) ? '0 : bank_rd[rd_port];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    mpreg_port_bank #(.CNT_W(CNT_W)) bank_i (
      .clk_i      (clk_i),
      .ifc_rst_i  (!aresetn_i),
      .core_rst_i (core_rst_i),
      .en_i       (port_en_i[p]),
      .evt_i      (evt_i[p*NCNT +: NCNT]),
      .we_i       (bank_we[p]),
      .wr_off_i   (wr_off),
      .wr_data_i  (wr_data),
      .wr_strb_i  (wr_strb),
      .rd_off_i   (rd_off),
      .rd_data_o  (bank_rd[p])
    );
  end

  // Debug pulses are registered on the same edge that raises the response valid.
  always_ff @(posedge clk_i) begin
    if (!aresetn_i || core_rst_i) begin
      dbg_dis_o <= 1'b0;
      dbg_unm_o <= 1'b0;
    end else begin
      dbg_dis_o <= (wr_fire && wr_dis) || (rd_fire && rd_dis);
      dbg_unm_o <= (wr_fire && !wr_dis && wr_unm) || (rd_fire && !rd_dis && rd_unm);
    end
  end
endmodule

// File: rtl/mpreg_axil_slave_chk.sv
module mpreg_axil_slave_chk (
  input logic       clk_i,
  input logic       aresetn_i,
  input logic       core_rst_i,
  input logic       s_awready,
  input logic       s_wready,
  input logic       s_bvalid,
  input logic       s_bready,
  input logic [1:0] s_bresp,
  input logic       s_arready,
  input logic       s_rvalid,
  input logic       s_rready,
  input logic [31:0] s_rdata,
  input logic [1:0] s_rresp,
  input logic       dbg_dis_o,
  input logic       dbg_unm_o
);
  // R1
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  // R1
  w_block_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    s_bvalid |-> !s_awready && !s_wready);
  // R2
  r_hold_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
  // R2
  ar_block_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    s_rvalid |-> !s_arready);
  // R3
  reset_idle_chk: assert property (@(posedge clk_i)
    !aresetn_i |=> !s_bvalid && !s_rvalid && !dbg_dis_o && !dbg_unm_o);
  // R5
  b_okay_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    $rose(s_bvalid) && !$past(core_rst_i) |-> s_bresp == 2'b00);
  // R5
  r_err_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    $rose(s_rvalid) && $past(core_rst_i) |-> s_rresp == 2'b10 && s_rdata == 32'h0);
  // R11
  dbg_align_chk: assert property (@(posedge clk_i) disable iff (!aresetn_i)
    dbg_dis_o || dbg_unm_o |-> $rose(s_bvalid) || $rose(s_rvalid));
endmodule

bind mpreg_axil_slave mpreg_axil_slave_chk chk_i (
  .clk_i      (clk_i),
  .aresetn_i  (aresetn_i),
  .core_rst_i (core_rst_i),
  .s_awready  (s_awready),
  .s_wready   (s_wready),
  .s_bvalid   (s_bvalid),
  .s_bready   (s_bready),
  .s_bresp    (s_bresp),
  .s_arready  (s_arready),
  .s_rvalid   (s_rvalid),
  .s_rready   (s_rready),
  .s_rdata    (s_rdata),
  .s_rresp    (s_rresp),
  .dbg_dis_o  (dbg_dis_o),
  .dbg_unm_o  (dbg_unm_o)
);

// File: tb/mpreg_axil_slave_tb_top.sv
module mpreg_axil_slave_tb_top;
  localparam int NP = 4;
  localparam int CW = 6;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic aresetn = 1'b0, core_rst = 1'b0;
  logic [NP-1:0] port_en = 4'b1011;
  logic [NP*8-1:0] evt = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0, s_bready = 1, s_rready = 1;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic [31:0] s_wdata = '0;
  logic [3:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, dbg_dis, dbg_unm;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;

  mpreg_axil_slave #(.NPORTS(NP), .CNT_W(CW)) dut_i (
    .clk_i(clk), .aresetn_i(aresetn), .core_rst_i(core_rst),
    .port_en_i(port_en), .evt_i(evt),
    .s_awvalid, .s_awready, .s_awaddr, .s_wvalid, .s_wready, .s_wdata, .s_wstrb,
    .s_bvalid, .s_bready, .s_bresp, .s_arvalid, .s_arready, .s_araddr,
    .s_rvalid, .s_rready, .s_rdata, .s_rresp,
    .dbg_dis_o(dbg_dis), .dbg_unm_o(dbg_unm)
  );

  typedef struct {
    logic [1:0]  resp;
    logic [31:0] data;
    logic        dis;
    logic        unm;
    string       tag;
  } exp_t;

  exp_t rd_q[$];
  exp_t wr_q[$];
  int n_chk = 0, n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr(input int p, input int off);
    return {p[1:0], off[7:0], 2'b00};
  endfunction

  // Monitor: pops expected items as responses complete.
  always @(negedge clk) begin
    exp_t e;
    if (s_rvalid && s_rready) begin
      if (rd_q.size() == 0) check("R2 unexpected read response", 32'd1, 32'd0);
      else begin
        e = rd_q.pop_front();
        check({e.tag, " rdata"}, s_rdata, e.data);
        check({e.tag, " rresp"}, 32'(s_rresp), 32'(e.resp));
        check({e.tag, " debug flags"}, {30'b0, dbg_dis, dbg_unm}, {30'b0, e.dis, e.unm});
      end
    end
    if (s_bvalid && s_bready) begin
      if (wr_q.size() == 0) check("R1 unexpected write response", 32'd1, 32'd0);
      else begin
        e = wr_q.pop_front();
        check({e.tag, " bresp"}, 32'(s_bresp), 32'(e.resp));
        check({e.tag, " debug flags"}, {30'b0, dbg_dis, dbg_unm}, {30'b0, e.dis, e.unm});
      end
    end
  end

  task automatic wr(input int p, input int off, input logic [31:0] d, input logic [3:0] st,
                    input int aw_lag, input int w_lag, input logic [1:0] rsp,
                    input logic dis, input logic unm, input string tag);
    exp_t e;
    int c = 0;
    bit ad = 0, wd = 0, a, w;
    e.resp = rsp; e.data = '0; e.dis = dis; e.unm = unm; e.tag = tag;
    wr_q.push_back(e);
    while (!(ad && wd)) begin
      @(negedge clk);
      if (ad) s_awvalid = 0;
      else if (c >= aw_lag) begin s_awvalid = 1; s_awaddr = addr(p, off); end
      if (wd) s_wvalid = 0;
      else if (c >= w_lag) begin s_wvalid = 1; s_wdata = d; s_wstrb = st; end
      if (ad && !wd) check({tag, " R1 awready low while W pending"}, 32'(s_awready), 32'd0);
      if (wd && !ad) check({tag, " R1 wready low while AW pending"}, 32'(s_wready), 32'd0);
      a = s_awvalid && s_awready;
      w = s_wvalid && s_wready;
      @(posedge clk);
      if (a) ad = 1;
      if (w) wd = 1;
      c++;
    end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    while (wr_q.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input int p, input int off, input logic [31:0] d, input logic [1:0] rsp,
                    input logic dis, input logic unm, input string tag);
    exp_t e;
    bit a;
    e.resp = rsp; e.data = d; e.dis = dis; e.unm = unm; e.tag = tag;
    rd_q.push_back(e);
    @(negedge clk);
    s_arvalid = 1; s_araddr = addr(p, off);
    do begin
      a = s_arready;
      @(posedge clk);
      @(negedge clk);
    end while (!a);
    s_arvalid = 0;
    while (rd_q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse_evt(input int idx, input int n);
    @(negedge clk);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R3: idle outputs while the interface reset is held
    check("R3 bvalid in reset", 32'(s_bvalid), 0);
    check("R3 rvalid in reset", 32'(s_rvalid), 0);
    check("R3 debug flags in reset", {30'b0, dbg_dis, dbg_unm}, 0);
    aresetn = 1;
    @(negedge clk);
    check("R1 awready after reset", 32'(s_awready), 1);
    check("R2 arready after reset", 32'(s_arready), 1);

    // R6 R4: config write and read back
    wr(0, 8'h00, 32'hA5A5_1234, 4'hF, 0, 0, 2'b00, 0, 0, "R6 cfg write");
    rd(0, 8'h00, 32'hA5A5_1234, 2'b00, 0, 0, "R6 cfg readback");
    // R1: data before address
    wr(1, 8'h11, 32'hDEAD_BEEF, 4'hF, 2, 0, 2'b00, 0, 0, "R1 W-first write");
    rd(1, 8'h11, 32'hDEAD_BEEF, 2'b00, 0, 0, "R1 W-first readback");
    // R1: address before data
    wr(3, 8'h15, 32'h0000_0005, 4'hF, 0, 3, 2'b00, 0, 0, "R1 AW-first write");
    rd(3, 8'h15, 32'h0000_0005, 2'b00, 0, 0, "R6 reset-control readback");
    // R7: byte lanes 0 and 2
    wr(1, 8'h11, 32'h1122_3344, 4'b0101, 0, 0, 2'b00, 0, 0, "R7 strobed write");
    rd(1, 8'h11, 32'hDE22_BE44, 2'b00, 0, 0, "R7 strobed readback");

    // R9 R10: counters and sticky status on port 0
    pulse_evt(0, 5);
    pulse_evt(1, 3);
    pulse_evt(5, 1);
    pulse_evt(2*8 + 0, 4);
    rd(0, 8'h20, 32'd5, 2'b00, 0, 0, "R9 counter 0");
    rd(0, 8'h21, 32'd3, 2'b00, 0, 0, "R9 counter 1");
    rd(0, 8'h25, 32'd1, 2'b00, 0, 0, "R9 counter 5");
    rd(0, 8'h18, 32'd1, 2'b00, 0, 0, "R10 status word 0");
    rd(0, 8'h19, 32'd3, 2'b00, 0, 0, "R10 status word 1");
    rd(0, 8'h1A, 32'd0, 2'b00, 0, 0, "R10 status word 2");
    // R8: read-only classes ignore writes
    wr(0, 8'h20, 32'hFFFF_FFFF, 4'hF, 0, 0, 2'b00, 0, 0, "R8 counter write");
    rd(0, 8'h20, 32'd5, 2'b00, 0, 0, "R8 counter unchanged");
    wr(0, 8'h19, 32'h0, 4'hF, 0, 0, 2'b00, 0, 0, "R8 status write");
    rd(0, 8'h19, 32'd3, 2'b00, 0, 0, "R8 status unchanged");
    // R9: saturation
    pulse_evt(1*8 + 7, 70);
    rd(1, 8'h27, 32'd63, 2'b00, 0, 0, "R9 saturated counter");

    // R11: disabled port 2
    rd(2, 8'h20, 32'd0, 2'b00, 1, 0, "R11 disabled read");
    wr(2, 8'h10, 32'h1234_5678, 4'hF, 0, 0, 2'b00, 1, 0, "R11 disabled write");
    rd(2, 8'h30, 32'd0, 2'b00, 1, 0, "R11 disabled and unmapped");
    port_en = 4'b1111;
    rd(2, 8'h10, 32'd0, 2'b00, 0, 0, "R11 write to disabled port ignored");
    rd(2, 8'h20, 32'd0, 2'b00, 0, 0, "R9 events while disabled not counted");
    // R12: unmapped offsets
    rd(0, 8'h1C, 32'd0, 2'b00, 0, 1, "R12 unmapped read gap");
    wr(0, 8'h30, 32'hFFFF_FFFF, 4'hF, 0, 0, 2'b00, 0, 1, "R12 unmapped write");
    rd(3, 8'hFF, 32'd0, 2'b00, 0, 1, "R12 unmapped read top");

    // R2: read back-pressure
    s_rready = 0;
    fork rd(0, 8'h00, 32'hA5A5_1234, 2'b00, 0, 0, "R2 held read"); join_none
    wait (s_rvalid);
    repeat (3) begin
      @(negedge clk);
      check("R2 rvalid held", 32'(s_rvalid), 1);
      check("R2 arready low while held", 32'(s_arready), 0);
    end
    s_rready = 1;
    wait (rd_q.size() == 0);
    // R1: write back-pressure
    s_bready = 0;
    fork wr(0, 8'h12, 32'h0000_00AA, 4'hF, 0, 0, 2'b00, 0, 0, "R1 held write"); join_none
    wait (s_bvalid);
    repeat (3) begin
      @(negedge clk);
      check("R1 bvalid held", 32'(s_bvalid), 1);
      check("R1 awready low while held", 32'(s_awready), 0);
    end
    s_bready = 1;
    wait (wr_q.size() == 0);
    repeat (2) @(negedge clk);

    // R3: interface reset with an address captured
    @(negedge clk);
    s_awvalid = 1; s_awaddr = addr(1, 8'h10);
    @(negedge clk);
    s_awvalid = 0;
    aresetn = 0;
    repeat (2) @(negedge clk);
    aresetn = 1;
    repeat (3) @(negedge clk);
    check("R3 dropped write gives no response", 32'(s_bvalid), 0);
    check("R3 awready after abort", 32'(s_awready), 1);
    rd(0, 8'h00, 32'hA5A5_1234, 2'b00, 0, 0, "R4 cfg kept over interface reset");
    rd(1, 8'h11, 32'd0, 2'b00, 0, 0, "R3 scratch cleared");
    rd(3, 8'h15, 32'd0, 2'b00, 0, 0, "R3 reset-control cleared");
    rd(0, 8'h20, 32'd0, 2'b00, 0, 0, "R3 counter cleared");
    rd(0, 8'h18, 32'd0, 2'b00, 0, 0, "R3 status cleared");
    pulse_evt(0, 2);
    rd(0, 8'h20, 32'd2, 2'b00, 0, 0, "R3 counter resumes from zero");

    // R5: core reset
    @(negedge clk);
    core_rst = 1;
    rd(0, 8'h00, 32'd0, 2'b10, 0, 0, "R5 read under core reset");
    wr(0, 8'h10, 32'h7, 4'hF, 0, 0, 2'b10, 0, 0, "R5 write under core reset");
    rd(2, 8'h30, 32'd0, 2'b10, 0, 0, "R5 no debug pulse under core reset");
    @(negedge clk);
    core_rst = 0;
    rd(0, 8'h00, 32'd0, 2'b00, 0, 0, "R4 cfg cleared by core reset");
    rd(0, 8'h10, 32'd0, 2'b00, 0, 0, "R5 scratch after core reset");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule